// File: doc/BRIEF.md
# Vertical Sync Period Counter

This block measures the time between successive rising edges of a vertical sync input. A free-running counter advances once for every cycle in which the timebase tick enable is high, which is nominally one pulse every 8 µs. When a VSYNC rising edge is recognised, the running count is copied into a read-only result register and the counter starts again from zero, so the result always holds the length of the most recent complete frame in ticks.

If VSYNC stops, or its period grows beyond the counter's range, the counter stops at its all-ones value and raises a sticky overflow flag. The flag appears both as an output pin and in the top bit of the high result byte. It stays high until software writes a one to a separate clear bit. Software reads the result through a one-bit-addressed byte port. Firmware divides the result into a frame rate and uses that to identify the video mode.

Top module: `vpm_top`

## Requirements
- R1: While no VSYNC edge is being recognised, the counter advances by exactly one on each clock cycle in which `tick_en` is high, and holds its value when `tick_en` is low.
- R2: A rising edge on `vsync_in` is recognised after a two-flop synchroniser. The result register takes the count in the third clock edge after `vsync_in` is first sampled high. In that same edge the counter returns to zero, and a tick in that cycle is not counted. At all other times the result register holds its value.
- R3: Reading address 0 returns result bits 7..0. Reading address 1 returns result bits 13..8 in data bits 5..0, zero in bit 6, and the overflow flag in bit 7.
- R4: A tick that arrives while the counter is at 16383, with no VSYNC recognised in that cycle, sets the overflow flag. The counter stays at 16383 until the next VSYNC edge.
- R5: The overflow flag is sticky. A write to address 1 with data bit 6 set clears it. If the counter overflows again in the same cycle, setting the flag wins over clearing it.
- R6: Writes to address 0, and writes to address 1 with bit 6 clear, change neither the result, the count nor the flag.
- R7: When a recognised VSYNC edge and a clear write fall in the same cycle, the result is latched and the counter restarts as usual, and the flag is cleared.
- R8: A VSYNC input that stays high produces one recognition only. A falling edge produces none.
- R9: After reset, both readable bytes are zero and `ovf_flag` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase pulse, one cycle per 8 µs period |
| vsync_in | input | 1 | Vertical sync, asynchronous to clk |
| reg_addr | input | 1 | Byte select: 0 low result byte, 1 high byte with flag |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data; bit 6 at address 1 clears the flag |
| reg_rdata | output | 8 | Read data for the selected byte |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The assertions take for granted that `vsync_in` holds each level for at least two clock cycles. Under that condition the synchroniser never swallows a pulse, and recognition events are always separated by idle cycles. They also take for granted that `tick_en` is a clean single-cycle level that the block samples directly. The stimulus drives VSYNC pulses and gaps no shorter than three cycles, changes inputs only on the falling clock edge, and lets ticks arrive at random densities, including back-to-back runs long enough to reach saturation.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  localparam int VPM_CNT_W   = 14;
  localparam int VPM_DATA_W  = 8;
  localparam int VPM_SYNC_N  = 2;

  typedef enum logic {
    REG_LO = 1'b0,
    REG_HI = 1'b1
  } vpm_reg_e;
endpackage

// File: rtl/vpm_sync_edge.sv
module vpm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_evt
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];
  end

  assign rise_evt = chain[STAGES-1] & ~prev_q;

  // R8: one recognition per rising edge, never two adjacent cycles
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !rise_evt);
endmodule

// File: rtl/vpm_period_counter.sv
module vpm_period_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             vs_evt,
  input  logic             clr_req,
  output logic [CNT_W-1:0] result,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt,
  output logic             ovf_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic at_limit(input logic [CNT_W-1:0] c);
    return c == CNT_MAX;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] c, input logic tick, input logic evt);
    if (evt)                      return '0;
    else if (tick && !at_limit(c)) return c + 1'b1;
    else                          return c;
  endfunction

  assign ovf_evt = tick_en & ~vs_evt & at_limit(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      result <= '0;
    end else begin
      count <= next_count(count, tick_en, vs_evt);
      if (vs_evt) result <= count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf_evt) ovf_flag <= 1'b1;
    else if (clr_req) ovf_flag <= 1'b0;
  end

  p_incr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !vs_evt && !at_limit(count)) |=> count == $past(count) + 1'b1);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !vs_evt) |=> $stable(count));
  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vs_evt |=> (result == $past(count)) && (count == '0));
  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_evt |=> $stable(result));
  p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit(count) && !vs_evt) |=> at_limit(count));
  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_req) |=> ovf_flag);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !ovf_evt) |=> !ovf_flag);
  p_coincide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_evt && clr_req) |=> (result == $past(count)) && !ovf_flag);
endmodule

// File: rtl/vpm_regs.sv
module vpm_regs #(
  parameter int CNT_W  = 14,
  parameter int DATA_W = 8
) (
  input  logic              addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  result,
  input  logic              ovf_flag,
  output logic [DATA_W-1:0] rdata,
  output logic              clr_req
);
  import vpm_pkg::*;

  localparam int FLAG_BIT = DATA_W - 1;
  localparam int CLR_BIT  = DATA_W - 2;
  localparam int HI_W     = CNT_W - DATA_W;

  function automatic logic [DATA_W-1:0] pack_hi(
    input logic [CNT_W-1:0] r, input logic f);
    logic [DATA_W-1:0] b;
    b = '0;
    b[HI_W-1:0] = r[CNT_W-1:DATA_W];
    b[FLAG_BIT] = f;
    return b;
  endfunction

  assign clr_req = wr_en & (addr == REG_HI) & wdata[CLR_BIT];

  always_comb begin
    if (addr == REG_HI) rdata = pack_hi(result, ovf_flag);
    else                rdata = result[DATA_W-1:0];
  end
endmodule

// File: rtl/vpm_top.sv
module vpm_top #(
  parameter int CNT_W   = vpm_pkg::VPM_CNT_W,
  parameter int DATA_W  = vpm_pkg::VPM_DATA_W,
  parameter int SYNC_N  = vpm_pkg::VPM_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              vsync_in,
  input  logic              reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ovf_flag
);
  logic             vs_evt;
  logic             clr_req;
  logic             ovf_evt;
  logic [CNT_W-1:0] result;
  logic [CNT_W-1:0] count;

  vpm_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (vsync_in),
    .rise_evt (vs_evt)
  );

  vpm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .vs_evt   (vs_evt),
    .clr_req  (clr_req),
    .result   (result),
    .count    (count),
    .ovf_evt  (ovf_evt),
    .ovf_flag (ovf_flag)
  );

  vpm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .addr     (reg_addr),
    .wr_en    (reg_wr_en),
    .wdata    (reg_wdata),
    .result   (result),
    .ovf_flag (ovf_flag),
    .rdata    (reg_rdata),
    .clr_req  (clr_req)
  );

  // R6: a write that is not a clear leaves the flag alone
  p_noclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !clr_req && ovf_flag) |=> ovf_flag);
endmodule

// File: tb/vpm_top_tb.sv
module vpm_top_tb;
  localparam int MAXC = 16383;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       vsync_in = 1'b0;
  logic       reg_addr = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ovf_flag;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R9";
  bit done = 0;

  // reference model state
  int m_s1 = 0, m_s2 = 0, m_s3 = 0;
  int m_cnt = 0, m_res = 0, m_flg = 0;

  always #2.5 clk = ~clk;

  vpm_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .vsync_in(vsync_in),
    .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_flag(ovf_flag)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_cnt = 0; m_res = 0; m_flg = 0;
    end else begin
      bit ev, setf, clr;
      ev   = (m_s2 == 1) && (m_s3 == 0);
      setf = 0;
      clr  = reg_wr_en && reg_addr && reg_wdata[6];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = vsync_in;
      if (ev) begin
        m_res = m_cnt;
        m_cnt = 0;
      end else if (tick_en) begin
        if (m_cnt == MAXC) setf = 1;
        else m_cnt = m_cnt + 1;
      end
      if (setf) m_flg = 1;
      else if (clr) m_flg = 0;
    end
  end

  task automatic check_now();
    int exp;
    exp = reg_addr ? ((m_flg << 7) | (m_res >> 8)) : (m_res & 255);
    checks++;
    if (reg_rdata !== exp[7:0] || ovf_flag !== m_flg[0]) begin
      fails++;
      $display("FAIL %s: addr=%0d rdata=%h flag=%b expected rdata=%h flag=%0d",
               cur_req, reg_addr, reg_rdata, ovf_flag, exp[7:0], m_flg);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check_now();
      reg_addr = 1'($urandom % 2);
    end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
    check_now();
  endtask

  task automatic frame(int gap, int density);
    vsync_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick_en = (($urandom % 100) < density);
      step(1);
    end
    vsync_in = 1'b0;
    for (int i = 0; i < gap; i++) begin
      tick_en = (($urandom % 100) < density);
      step(1);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset state on both bytes
    cur_req = "R9";
    reg_addr = 1'b0; step(2);
    reg_addr = 1'b1; step(2);
    rst_n = 1'b1;
    reg_addr = 1'b0; step(1);
    reg_addr = 1'b1; step(1);

    // R1: counting with ticks at varied densities, no VSYNC
    cur_req = "R1";
    for (int i = 0; i < 200; i++) begin
      tick_en = (($urandom % 3) != 0);
      step(1);
    end
    tick_en = 1'b0; step(10);

    // R2: frames of varied length, result latched and counter restarted
    cur_req = "R2";
    frame(40, 100);
    frame(300, 50);
    frame(1000, 80);
    frame(25, 10);
    frame(700, 100);

    // R3: byte layout; a result above 255 exercises both bytes
    cur_req = "R3";
    tick_en = 1'b1;
    frame(900, 100);
    frame(5, 0);
    reg_addr = 1'b0; step(1);
    reg_addr = 1'b1; step(1);

    // R8: VSYNC held high then released gives one latch only
    cur_req = "R8";
    vsync_in = 1'b1;
    for (int i = 0; i < 60; i++) begin tick_en = 1'b1; step(1); end
    vsync_in = 1'b0;
    for (int i = 0; i < 60; i++) begin tick_en = 1'b1; step(1); end

    // R6: writes that must not change anything
    cur_req = "R6";
    wr(1'b0, 8'hFF);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hBF);
    wr(1'b1, 8'h00);
    step(4);

    // R4: no VSYNC for more than 16383 ticks saturates and sets the flag
    cur_req = "R4";
    tick_en = 1'b1;
    step(16500);
    tick_en = 1'b0;
    step(4);

    // R6 again with the flag set: non-clear writes keep it
    cur_req = "R6";
    wr(1'b1, 8'hBF);
    wr(1'b0, 8'h40);
    step(2);

    // R5: set wins over clear when overflow repeats in the same cycle
    cur_req = "R5";
    tick_en = 1'b1;
    wr(1'b1, 8'h40);
    tick_en = 1'b0;
    step(2);
    wr(1'b1, 8'h40);
    step(3);
    tick_en = 1'b1; step(2);
    tick_en = 1'b0; step(2);

    // R2: a VSYNC after saturation latches 16383
    cur_req = "R2";
    frame(20, 50);

    // R7: VSYNC recognition and clear write in the same cycle
    cur_req = "R7";
    tick_en = 1'b1;
    step(16400);
    tick_en = 1'b0;
    vsync_in = 1'b1;
    step(2);
    wr(1'b1, 8'h40);
    step(3);
    vsync_in = 1'b0;
    for (int i = 0; i < 100; i++) begin tick_en = (($urandom % 2) == 0); step(1); end

    // R1: mixed traffic to close
    cur_req = "R1";
    for (int i = 0; i < 6; i++) frame(50 + i * 37, 30 + i * 10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule